// File: doc/BRIEF.md
# Multiplexed LED Capacity Display

This block lights a row of five LED segments to show how much charge is left in a battery pack, as a share of the pack's learned full capacity. Each segment stands for one fifth of that full capacity, and the segments fill from segment 1 upward. The block receives the remaining and full capacity values as plain numbers. Capacity compensation and the division of the counts are done elsewhere.

A two-bit display-mode input carries the decoded state of a three-state strap pin. In the high state the display is dark. In the floating state the display follows a charge-in-progress flag. Moving into the low state starts a four-second one-shot, so a push-button can wake the display. The floating and low requests combine by OR.

The lit segments are not driven together. Odd segments (1, 3, 5) and even segments (2, 4) form two banks. The banks take turns within a 10 ms frame, and each bank is on for 30% of that frame. Two end-of-discharge flags change the picture. The first makes segment 1 blink at 4 Hz. The final one blanks the whole display. All timing comes from a 1 kHz tick enable, which is derived from a system clock frequency parameter.

Top module: `cap_led_display`

## Requirements
- R1: The number of lit segments is ceil(5 × remain / full), capped at 5. Lit segments are always the lowest-numbered ones: seg_o[0] is segment 1, and seg_o[k] may show only when remain × 5 > k × full.
- R2: When full capacity is zero, no segment ever turns on.
- R3: A mode_i value of 2'b01 (pin high) or 2'b11 keeps every segment output low, whatever the other inputs are.
- R4: With mode_i = 2'b10 (pin floating), the display is active while chg_i is 1 and dark while chg_i is 0 (unless a one-shot is still running).
- R5: Entering mode_i = 2'b00 (pin low) from any other mode starts a one-shot of 4000 ticks (4 s). The display stays active until the one-shot ends and goes dark afterwards, even if the pin is still held low.
- R6: Entering low mode again while a one-shot is running restarts the full 4 s period.
- R7: Segments 1, 3 and 5 belong to bank A and segments 2 and 4 belong to bank B. No cycle ever has an output of bank A and an output of bank B high together.
- R8: The two banks take turns in a 10-tick (100 Hz) frame. Each lit segment is high for 3 of every 10 ticks (30%).
- R9: While edv1_i is 1, segment 1 is further gated by a 4 Hz square wave (125 ticks on, 125 off). The other segments are not affected.
- R10: While edvf_i is 1, every segment output is low, and this takes priority over every mode.
- R11: The reset is synchronous and active low. It clears all outputs, timers and phases, and seg_o stays low for as long as rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| remain_i | input | CAP_W | Remaining capacity count |
| full_i | input | CAP_W | Learned full capacity count |
| mode_i | input | 2 | Decoded display pin: 00 low, 01 high, 10 floating, 11 treated as high |
| chg_i | input | 1 | Charge in progress |
| edv1_i | input | 1 | First end-of-discharge flag (low battery) |
| edvf_i | input | 1 | Final end-of-discharge flag |
| seg_o | output | NUM_SEG | Segment drive, bit 0 is segment 1, active high |

## Verification
The level table exercises the exact boundaries of the ceiling rule. At 20% of full, one segment must show and not two; one count above, two must show. A design that rounds down or adds one will light the wrong segment count at these points. The table also covers full = 0 and values above full.

Each segment's on-time is measured over whole multiplex frames, and the bench checks that no two banks are ever on in the same cycle. A wrong phase decode would break the 30% share or let the banks overlap.

The one-shot is checked at 3.5 s and at 4.5 s after a trigger. It is also checked after a retrigger at the 2 s mark. A timer that ignores the retrigger goes dark too early, and one that re-arms from a level instead of an entry into low mode never goes dark.

The low-battery blink is checked by requiring that segment 1 shows less than segment 3 but more than nothing. The blanking flag is checked against every active mode.

// File: rtl/cld_pkg.sv
// Package: shared mode encoding and timing constants for the LED capacity
// display. All timing constants count ticks of a 1 kHz enable.
package cld_pkg;

    // Decoded state of the three-state display pin.
    typedef enum logic [1:0] {
        DM_LOW      = 2'b00,
        DM_HIGH     = 2'b01,
        DM_FLOAT    = 2'b10,
        DM_HIGH_ALT = 2'b11
    } disp_mode_e;

    localparam int TICK_HZ        = 1000; // tick enable rate
    localparam int MUX_TICKS      = 10;   // multiplex frame, 100 Hz
    localparam int BANK_ON_TICKS  = 3;    // 30% of the frame per bank
    localparam int BANK_B_START   = 5;    // bank B phase offset in the frame
    localparam int BLINK_TICKS    = 250;  // low-battery blink period, 4 Hz
    localparam int ONESHOT_TICKS  = 4000; // on-time after a low-mode request

endpackage

// File: rtl/cld_tick_gen.sv
// Module: cld_tick_gen
// Produces a one-cycle enable every DIV clocks.
// Assumes DIV >= 1. A DIV of 1 gives an enable on every cycle.
module cld_tick_gen #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Free-running divider that wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
        else                             cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == CW'(DIV - 1));

    p_tick_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DIV - 1));

endmodule

// File: rtl/cld_level_calc.sv
// Module: cld_level_calc
// Turns remaining/full capacity into a thermometer of lit segments.
// Bit k is set when remain*NUM_SEG > k*full, which is the same as
// k < ceil(NUM_SEG*remain/full). The result caps itself at NUM_SEG.
// Assumes purely combinational use. The caller registers the result.
module cld_level_calc #(
    parameter int CAP_W   = 16,
    parameter int NUM_SEG = 5
) (
    input  logic [CAP_W-1:0]   remain_i,
    input  logic [CAP_W-1:0]   full_i,
    output logic [NUM_SEG-1:0] lit_o
);
    localparam int PW = CAP_W + $clog2(NUM_SEG + 1);

    logic [PW-1:0] scaled_rem;
    logic          full_nz;

    assign scaled_rem = PW'(remain_i) * PW'(NUM_SEG);
    assign full_nz    = (full_i != '0);

    // One comparator per segment threshold.
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_thr
        logic [PW-1:0] thr;
        assign thr      = PW'(full_i) * PW'(k);
        assign lit_o[k] = full_nz && (scaled_rem > thr);
    end

endmodule

// File: rtl/cld_phase_timer.sv
// Module: cld_phase_timer
// Holds the three tick-driven time bases: the bank multiplex phase, the
// low-battery blink phase, and the display one-shot. trig_i loads the
// one-shot to its full length, so a retrigger restarts it.
// Assumes tick_i is a one-cycle enable at TICK_HZ.
module cld_phase_timer
    import cld_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trig_i,
    output logic bank_a_o,
    output logic bank_b_o,
    output logic blink_o,
    output logic hold_o
);
    localparam int MW = $clog2(MUX_TICKS);
    localparam int BW = $clog2(BLINK_TICKS);
    localparam int OW = $clog2(ONESHOT_TICKS + 1);

    logic [MW-1:0] mux_ph_q;
    logic [BW-1:0] blk_ph_q;
    logic [OW-1:0] os_cnt_q;

    // Multiplex phase counts through one frame per MUX_TICKS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) mux_ph_q <= '0;
        else if (tick_i)
            mux_ph_q <= (mux_ph_q == MW'(MUX_TICKS - 1)) ? '0 : mux_ph_q + 1'b1;
    end

    // Blink phase counts through one blink period.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_ph_q <= '0;
        else if (tick_i)
            blk_ph_q <= (blk_ph_q == BW'(BLINK_TICKS - 1)) ? '0 : blk_ph_q + 1'b1;
    end

    // One-shot: load on trigger, count down on ticks to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                         os_cnt_q <= '0;
        else if (trig_i)                    os_cnt_q <= OW'(ONESHOT_TICKS);
        else if (tick_i && os_cnt_q != '0)  os_cnt_q <= os_cnt_q - 1'b1;
    end

    assign bank_a_o = (mux_ph_q < MW'(BANK_ON_TICKS));
    assign bank_b_o = (mux_ph_q >= MW'(BANK_B_START)) &&
                      (mux_ph_q <  MW'(BANK_B_START + BANK_ON_TICKS));
    assign blink_o  = (blk_ph_q < BW'(BLINK_TICKS / 2));
    assign hold_o   = (os_cnt_q != '0);

    p_banks_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_a_o && bank_b_o));

    p_restart_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (os_cnt_q == OW'(ONESHOT_TICKS)));

    p_hold_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_i && tick_i && os_cnt_q != '0) |=> (os_cnt_q == $past(os_cnt_q) - 1'b1));

    p_mux_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && mux_ph_q == MW'(MUX_TICKS - 1)) |=> (mux_ph_q == '0));

endmodule

// File: rtl/cap_led_display.sv
// Module: cap_led_display (top)
// Five-segment relative capacity display with two-bank multiplexing,
// a low-mode one-shot, a low-battery blink on segment 1 and a blanking
// flag. The outputs are registered, so seg_o follows the inputs one clock later.
// Assumes CLK_HZ is a multiple of the 1 kHz tick rate and mode_i is
// already synchronised to clk.
module cap_led_display
    import cld_pkg::*;
#(
    parameter int CLK_HZ  = 1_000_000,
    parameter int CAP_W   = 16,
    parameter int NUM_SEG = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAP_W-1:0]   remain_i,
    input  logic [CAP_W-1:0]   full_i,
    input  logic [1:0]         mode_i,
    input  logic               chg_i,
    input  logic               edv1_i,
    input  logic               edvf_i,
    output logic [NUM_SEG-1:0] seg_o
);
    localparam int TICK_DIV = CLK_HZ / TICK_HZ;

    disp_mode_e         mode_cur, mode_q;
    logic               tick, trig, show;
    logic               bank_a, bank_b, blink, hold;
    logic               mode_dark;
    logic [NUM_SEG-1:0] lit, seg_d;

    assign mode_cur = disp_mode_e'(mode_i);

    cld_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    cld_level_calc #(.CAP_W(CAP_W), .NUM_SEG(NUM_SEG)) u_level (
        .remain_i (remain_i),
        .full_i   (full_i),
        .lit_o    (lit)
    );

    cld_phase_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .trig_i   (trig),
        .bank_a_o (bank_a),
        .bank_b_o (bank_b),
        .blink_o  (blink),
        .hold_o   (hold)
    );

    // Remember the previous mode so that only an entry into low triggers.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= DM_HIGH;
        else        mode_q <= mode_cur;
    end

    assign trig      = (mode_cur == DM_LOW) && (mode_q != DM_LOW);
    assign mode_dark = (mode_cur == DM_HIGH) || (mode_cur == DM_HIGH_ALT);
    assign show      = !edvf_i && !mode_dark &&
                       (((mode_cur == DM_FLOAT) && chg_i) || hold);

    // Per-segment gating: bank by index parity, blink on the first segment.
    for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
        logic bank_on, blink_ok;
        if (k % 2 == 0) begin : g_bank_a
            assign bank_on = bank_a;
        end else begin : g_bank_b
            assign bank_on = bank_b;
        end
        if (k == 0) begin : g_blink
            assign blink_ok = !edv1_i || blink;
        end else begin : g_steady
            assign blink_ok = 1'b1;
        end
        assign seg_d[k] = show && lit[k] && bank_on && blink_ok;
    end

    // Output register for glitch-free segment drive.
    always_ff @(posedge clk) begin
        if (!rst_n) seg_o <= '0;
        else        seg_o <= seg_d;
    end

    p_high_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01 || mode_i == 2'b11) |=> (seg_o == '0));

    p_edvf_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        edvf_i |=> (seg_o == '0));

    p_empty_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_i == '0) |=> (seg_o == '0));

    p_float_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && !chg_i && !hold) |=> (seg_o == '0));

    p_thermo_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((lit & (lit + 1'b1)) == '0));

endmodule

// File: tb/cap_led_display_tb.sv
// Bench for cap_led_display. A scaled clock parameter gives 5 clocks per tick,
// so a multiplex frame is 50 cycles and a bank is on for 15 of them.
module cap_led_display_tb;
    localparam int CLK_HZ = 5000;
    localparam int TPT    = 5;         // clocks per tick
    localparam int FRAME  = 10 * TPT;  // multiplex frame in clocks
    localparam int BANKC  = 3 * TPT;   // on-clocks per bank per frame
    localparam int SEC    = 1000 * TPT;

    localparam int NV = 12;
    localparam int V_REM  [NV] = '{0, 1, 20, 21, 60, 61, 81, 100, 150, 50, 65535, 1};
    localparam int V_FULL [NV] = '{100, 100, 100, 100, 100, 100, 100, 100, 100, 0, 65535, 65535};
    localparam int V_CNT  [NV] = '{0, 1, 1, 2, 3, 4, 5, 5, 5, 0, 5, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] remain = 16'd100;
    logic [15:0] full = 16'd100;
    logic [1:0]  mode = 2'b10;
    logic        chg = 1'b1;
    logic        edv1 = 1'b0;
    logic        edvf = 1'b0;
    logic [4:0]  seg;

    int tests = 0;
    int fails = 0;
    int cnt [5];
    int overlap;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cap_led_display #(.CLK_HZ(CLK_HZ), .CAP_W(16), .NUM_SEG(5)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .remain_i (remain),
        .full_i   (full),
        .mode_i   (mode),
        .chg_i    (chg),
        .edv1_i   (edv1),
        .edvf_i   (edvf),
        .seg_o    (seg)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Count high cycles per segment and bank overlaps over n cycles.
    task automatic measure(input int n);
        for (int k = 0; k < 5; k++) cnt[k] = 0;
        overlap = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            for (int k = 0; k < 5; k++) if (seg[k]) cnt[k]++;
            if ((seg[0] | seg[2] | seg[4]) && (seg[1] | seg[3])) overlap++;
        end
    endtask

    function automatic int total();
        return cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4];
    endfunction

    initial begin
        // R11: dark during reset although inputs ask for a full display
        wait_clk(5);
        check(seg == 5'b0, "R11 seg during reset", int'(seg), 0);
        rst_n = 1'b1;
        #1;
        check(seg == 5'b0, "R11 seg right after reset", int'(seg), 0);

        // R1 R2 R7 R8: vector walk in floating mode with charge in progress
        for (int v = 0; v < NV; v++) begin
            remain = 16'(V_REM[v]);
            full   = 16'(V_FULL[v]);
            wait_clk(10);
            measure(FRAME);
            for (int k = 0; k < 5; k++) begin
                int exp_c;
                exp_c = (k < V_CNT[v]) ? BANKC : 0;
                check(cnt[k] == exp_c, (V_FULL[v] == 0) ? "R2 empty full" : "R1 R8 level", cnt[k], exp_c);
            end
            check(overlap == 0, "R7 bank overlap", overlap, 0);
        end

        remain = 16'd100; full = 16'd100;
        // R4: floating with no charge is dark
        chg = 1'b0; wait_clk(10); measure(FRAME);
        check(total() == 0, "R4 float idle", total(), 0);
        // R3: high and 2'b11 stay dark even with charge
        chg = 1'b1; mode = 2'b01; wait_clk(10); measure(FRAME);
        check(total() == 0, "R3 mode high", total(), 0);
        mode = 2'b11; wait_clk(10); measure(FRAME);
        check(total() == 0, "R3 mode 11", total(), 0);
        // R10: final flag blanks floating display
        mode = 2'b10; edvf = 1'b1; wait_clk(10); measure(FRAME);
        check(total() == 0, "R10 edvf blank", total(), 0);
        edvf = 1'b0;
        // R9: blink on segment 1 only
        edv1 = 1'b1; wait_clk(10); measure(50 * FRAME);
        check(cnt[0] > 0 && cnt[0] < 50 * BANKC, "R9 seg1 blinks", cnt[0], 50 * BANKC / 2);
        check(cnt[2] == 50 * BANKC, "R9 seg3 steady", cnt[2], 50 * BANKC);
        edv1 = 1'b0;

        // R5: one-shot from low mode, no charge
        chg = 1'b0; mode = 2'b10; wait_clk(10);
        mode = 2'b00;
        wait_clk(3 * SEC + SEC / 2);
        measure(FRAME);
        check(cnt[2] == BANKC, "R5 on at 3.5 s", cnt[2], BANKC);
        wait_clk(SEC);
        measure(FRAME);
        check(total() == 0, "R5 off at 4.5 s held low", total(), 0);
        // R10: blanking during an active one-shot
        mode = 2'b10; wait_clk(3); mode = 2'b00;
        wait_clk(SEC); edvf = 1'b1; wait_clk(5); measure(FRAME);
        check(total() == 0, "R10 edvf over one-shot", total(), 0);
        edvf = 1'b0;
        wait_clk(4 * SEC);

        // R6: retrigger at 2 s extends the on-time
        mode = 2'b10; wait_clk(3); mode = 2'b00;
        wait_clk(2 * SEC);
        mode = 2'b10; wait_clk(3); mode = 2'b00;
        wait_clk(3 * SEC + SEC / 2);
        measure(FRAME);
        check(cnt[4] == BANKC, "R6 on after retrigger", cnt[4], BANKC);
        wait_clk(SEC);
        measure(FRAME);
        check(total() == 0, "R6 off 4.5 s after retrigger", total(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule